// File: doc/BRIEF.md
# Valiant Two-Phase Route Unit

This unit spreads traffic over a two-dimensional mesh by sending every packet through a randomly picked waypoint router. It has two independent parts. The injection side runs next to a network interface. When a new head flit enters the network, it labels the flit with a waypoint node and clears a one-bit leg flag. The waypoint comes from a free-running pseudo-random generator. The route side is a purely combinational per-hop step inside each router. It takes the router's own coordinates and the header fields, and it returns a one-hot output port together with the leg flag to write back into the header.

Each leg is dimension ordered: X is corrected fully before Y. While the flag is clear, the target is the waypoint. When the flit reaches the waypoint, the flag is set in that same step and the target switches to the final destination, so the flit is never ejected part way. A waypoint that matches the source or the destination turns the trip into a plain XY route. Any other waypoint can make the path longer than the minimal one. Flit storage, arbitration and links belong to the surrounding router.

Top module: `valiant_route_unit`

## Requirements
- R1: Every stamped waypoint lies inside the mesh: `stamp_mid_x` < MESH_X and `stamp_mid_y` < MESH_Y (default 4x4).
- R2: `stamp_valid` follows `inj_valid` in the same cycle, and `stamp_phase` is always 0.
- R3: The waypoint generator is never all-zero and advances every clock cycle. Across 1000 consecutive cycles, every one of the MESH_X*MESH_Y nodes is stamped at least once.
- R4: With `hdr_phase`=0 and the router not at the waypoint, the port steers toward the waypoint, X first. The port bits are: bit1 East (x+1), bit2 West (x-1), bit3 North (y+1), bit4 South (y-1). `route_phase` stays 0.
- R5: With `hdr_phase`=0 and the router at the waypoint, `route_phase` becomes 1 and the port steers toward the destination in the same evaluation, with the same X-then-Y rule.
- R6: With `hdr_phase`=1, the port steers toward the destination X first, and `route_phase` stays 1.
- R7: bit0 (Local) is selected exactly when `route_phase` is 1 and the router coordinates equal the destination.
- R8: Exactly one bit of `route_port` is set for every header.
- R9: A packet from (0,0) through waypoint (1,2) to (3,3) visits (1,0), (1,1), (1,2), (2,2), (3,2) and (3,3), and is then ejected.
- R10: A waypoint equal to the source or to the destination gives the same hop sequence as XY routing from source to destination.
- R11: After each reset release, the sequence of stamped waypoints restarts identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_valid | input | 1 | A new head flit is being injected |
| stamp_valid | output | 1 | Stamp fields are valid |
| stamp_mid_x | output | XW | Waypoint X coordinate |
| stamp_mid_y | output | YW | Waypoint Y coordinate |
| stamp_phase | output | 1 | Initial leg flag (0) |
| hop_x | input | XW | X coordinate of the router computing the route |
| hop_y | input | YW | Y coordinate of the router computing the route |
| hdr_dst_x | input | XW | Destination X from the header |
| hdr_dst_y | input | YW | Destination Y from the header |
| hdr_mid_x | input | XW | Waypoint X from the header |
| hdr_mid_y | input | YW | Waypoint Y from the header |
| hdr_phase | input | 1 | Leg flag from the header |
| route_port | output | 5 | One-hot output port (Local, East, West, North, South) |
| route_phase | output | 1 | Leg flag to write back into the header |

## Verification
The route-side assertions require every header coordinate and router coordinate to lie inside the mesh. They also require the header inputs to be stable across the sampling edge. The bench keeps to this in two ways. Random coordinates are drawn modulo the mesh size, and inputs change only on falling edges. Walks follow the unit's own port choice hop by hop, so the router position always stays a legal node.

// File: rtl/valiant_pkg.sv
package valiant_pkg;
  localparam int PORT_N = 5;
  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } port_e;

  function automatic logic [PORT_N-1:0] port_onehot(port_e p);
    logic [PORT_N-1:0] v;
    v = '0;
    v[p] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/via_picker.sv
module via_picker #(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [XW-1:0] mid_x,
  output logic [YW-1:0] mid_y
);
  localparam int NODES = MESH_X * MESH_Y;
  localparam int NW    = (NODES > 1) ? $clog2(NODES) : 1;
  localparam int PW    = LFSR_W + NW;

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_d;

  // Multiply-high fold: maps the generator state evenly onto 0..NODES-1.
  function automatic logic [NW-1:0] fold_index(logic [LFSR_W-1:0] v);
    logic [PW-1:0] prod;
    prod = {{NW{1'b0}}, v} * PW'(NODES);
    return prod[PW-1:LFSR_W];
  endfunction

  always_comb begin
    lfsr_d = lfsr_q >> 1;
    if (lfsr_q[0]) lfsr_d = lfsr_d ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_d;
  end

  logic [NW-1:0] node_idx;
  assign node_idx = fold_index(lfsr_q);
  assign mid_x    = XW'(int'(node_idx) % MESH_X);
  assign mid_y    = YW'(int'(node_idx) / MESH_X);

  a_r3_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
  a_r3_state_moves: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !$stable(lfsr_q));
  a_r11_seed_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> lfsr_q == SEED);
endmodule

// File: rtl/route_step.sv
module route_step
  import valiant_pkg::*;
#(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
  input  logic [XW-1:0]     cur_x,
  input  logic [YW-1:0]     cur_y,
  input  logic [XW-1:0]     dst_x,
  input  logic [YW-1:0]     dst_y,
  input  logic [XW-1:0]     mid_x,
  input  logic [YW-1:0]     mid_y,
  input  logic              phase_in,
  output logic [PORT_N-1:0] port_sel,
  output logic              phase_out,
  output logic              at_mid_turn
);
  // Dimension-ordered step: close X first, then Y, else eject.
  function automatic port_e xy_step(logic [XW-1:0] cx, logic [YW-1:0] cy,
                                    logic [XW-1:0] tx, logic [YW-1:0] ty);
    if (cx < tx)      return PORT_EAST;
    else if (cx > tx) return PORT_WEST;
    else if (cy < ty) return PORT_NORTH;
    else if (cy > ty) return PORT_SOUTH;
    else              return PORT_LOCAL;
  endfunction

  logic          at_mid;
  logic [XW-1:0] tgt_x;
  logic [YW-1:0] tgt_y;
  port_e         dir;

  assign at_mid      = (cur_x == mid_x) && (cur_y == mid_y);
  assign at_mid_turn = !phase_in && at_mid;
  assign phase_out   = phase_in || at_mid;
  assign tgt_x       = phase_out ? dst_x : mid_x;
  assign tgt_y       = phase_out ? dst_y : mid_y;
  assign dir         = xy_step(cur_x, cur_y, tgt_x, tgt_y);
  assign port_sel    = port_onehot(dir);
endmodule

// File: rtl/valiant_route_unit.sv
module valiant_route_unit
  import valiant_pkg::*;
#(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inj_valid,
  output logic              stamp_valid,
  output logic [XW-1:0]     stamp_mid_x,
  output logic [YW-1:0]     stamp_mid_y,
  output logic              stamp_phase,
  input  logic [XW-1:0]     hop_x,
  input  logic [YW-1:0]     hop_y,
  input  logic [XW-1:0]     hdr_dst_x,
  input  logic [YW-1:0]     hdr_dst_y,
  input  logic [XW-1:0]     hdr_mid_x,
  input  logic [YW-1:0]     hdr_mid_y,
  input  logic              hdr_phase,
  output logic [PORT_N-1:0] route_port,
  output logic              route_phase
);
  logic turn_event;

  via_picker #(.MESH_X(MESH_X), .MESH_Y(MESH_Y), .LFSR_W(LFSR_W),
               .SEED(SEED), .TAPS(TAPS)) u_pick (
    .clk(clk), .rst_n(rst_n), .mid_x(stamp_mid_x), .mid_y(stamp_mid_y));

  assign stamp_valid = inj_valid;
  assign stamp_phase = 1'b0;

  route_step #(.MESH_X(MESH_X), .MESH_Y(MESH_Y)) u_step (
    .cur_x(hop_x), .cur_y(hop_y), .dst_x(hdr_dst_x), .dst_y(hdr_dst_y),
    .mid_x(hdr_mid_x), .mid_y(hdr_mid_y), .phase_in(hdr_phase),
    .port_sel(route_port), .phase_out(route_phase), .at_mid_turn(turn_event));

  a_r1_mid_in_mesh: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_valid |-> (int'(stamp_mid_x) < MESH_X) && (int'(stamp_mid_y) < MESH_Y));
  a_r8_port_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(route_port) == 1);
  a_r6_phase_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_phase |-> route_phase);
  a_r5_turn_sets_phase: assert property (@(posedge clk) disable iff (!rst_n)
    turn_event |-> route_phase && !route_port[PORT_LOCAL] ||
                   (hop_x == hdr_dst_x && hop_y == hdr_dst_y));
  a_r7_local_only_at_dest: assert property (@(posedge clk) disable iff (!rst_n)
    route_port[PORT_LOCAL] |-> route_phase && hop_x == hdr_dst_x && hop_y == hdr_dst_y);
endmodule

// File: tb/test_valiant_route_unit.sv
module test_valiant_route_unit;
  localparam int MX = 4;
  localparam int MY = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inj_valid = 1'b0;
  logic       stamp_valid, stamp_phase, route_phase, hdr_phase = 1'b0;
  logic [1:0] stamp_mid_x, stamp_mid_y;
  logic [1:0] hop_x = '0, hop_y = '0, hdr_dst_x = '0, hdr_dst_y = '0;
  logic [1:0] hdr_mid_x = '0, hdr_mid_y = '0;
  logic [4:0] route_port;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  valiant_route_unit i_valiant_route_unit (
    .clk(clk), .rst_n(rst_n), .inj_valid(inj_valid), .stamp_valid(stamp_valid),
    .stamp_mid_x(stamp_mid_x), .stamp_mid_y(stamp_mid_y), .stamp_phase(stamp_phase),
    .hop_x(hop_x), .hop_y(hop_y), .hdr_dst_x(hdr_dst_x), .hdr_dst_y(hdr_dst_y),
    .hdr_mid_x(hdr_mid_x), .hdr_mid_y(hdr_mid_y), .hdr_phase(hdr_phase),
    .route_port(route_port), .route_phase(route_phase));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected port: bit0 Local, bit1 East, bit2 West, bit3 North, bit4 South
  function automatic int exp_port(int cx, int cy, int mx, int my, int dx, int dy, int ph);
    int tx, ty;
    bit second;
    second = (ph != 0) || (cx == mx && cy == my);
    tx = second ? dx : mx;
    ty = second ? dy : my;
    if (tx > cx) return 2;
    if (tx < cx) return 4;
    if (ty > cy) return 8;
    if (ty < cy) return 16;
    return 1;
  endfunction

  function automatic int exp_phase(int cx, int cy, int mx, int my, int ph);
    return ((ph != 0) || (cx == mx && cy == my)) ? 1 : 0;
  endfunction

  task automatic apply(int cx, int cy, int mx, int my, int dx, int dy, int ph);
    @(negedge clk);
    hop_x = 2'(cx); hop_y = 2'(cy); hdr_mid_x = 2'(mx); hdr_mid_y = 2'(my);
    hdr_dst_x = 2'(dx); hdr_dst_y = 2'(dy); hdr_phase = ph[0];
    #1;
  endtask

  // Walk with the unit, compare against an independently built two-leg path.
  task automatic walk(int sx, int sy, int mx, int my, int dx, int dy, string req);
    int ex[32]; int ey[32]; int n; int x; int y; int ph; bit ok;
    n = 0; x = sx; y = sy;
    while (x != mx) begin x += (mx > x) ? 1 : -1; ex[n] = x; ey[n] = y; n++; end
    while (y != my) begin y += (my > y) ? 1 : -1; ex[n] = x; ey[n] = y; n++; end
    while (x != dx) begin x += (dx > x) ? 1 : -1; ex[n] = x; ey[n] = y; n++; end
    while (y != dy) begin y += (dy > y) ? 1 : -1; ex[n] = x; ey[n] = y; n++; end
    x = sx; y = sy; ph = 0; ok = 1'b1;
    for (int h = 0; h <= n; h++) begin
      apply(x, y, mx, my, dx, dy, ph);
      if (h == n) begin
        check(route_port == 5'b00001, {req, " eject at end"}, route_port, 1);
      end else begin
        case (route_port)
          5'b00010: x++;
          5'b00100: x--;
          5'b01000: y++;
          5'b10000: y--;
          default: ok = 1'b0;
        endcase
        ph = route_phase;
        if (x != ex[h] || y != ey[h]) ok = 1'b0;
      end
      if (!ok) break;
    end
    check(ok, {req, " hop path"}, x * 10 + y, dx * 10 + dy);
  endtask

  task automatic capture(output int seq[8]);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      seq[i] = int'(stamp_mid_y) * MX + int'(stamp_mid_x);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int a[8]; int b[8]; int seen; bit range_ok; bit same;
    void'($urandom(32'd1234));
    // R11: the stamp sequence restarts on every reset release
    capture(a);
    capture(b);
    same = 1'b1;
    for (int i = 0; i < 8; i++) if (a[i] != b[i]) same = 1'b0;
    check(same, "R11 sequence repeats after reset", b[0], a[0]);

    // R2: reset-state and pass-through stamping
    @(negedge clk);
    check(stamp_valid == 1'b0, "R2 stamp_valid idle", stamp_valid, 0);
    inj_valid = 1'b1;
    #1;
    check(stamp_valid == 1'b1 && stamp_phase == 1'b0, "R2 stamp valid, phase 0",
          {stamp_valid, stamp_phase}, 2);

    // R1, R3: range and coverage over 1000 draws
    seen = 0; range_ok = 1'b1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (int'(stamp_mid_x) >= MX || int'(stamp_mid_y) >= MY) range_ok = 1'b0;
      seen |= 1 << (int'(stamp_mid_y) * MX + int'(stamp_mid_x));
    end
    check(range_ok, "R1 waypoint inside mesh", range_ok, 1);
    check(seen == 32'hFFFF, "R3 all nodes stamped", seen, 32'hFFFF);
    inj_valid = 1'b0;

    // R4, R5, R6, R7: directed single steps
    apply(0, 0, 2, 1, 3, 3, 0);
    check(route_port == 5'b00010 && !route_phase, "R4 east toward waypoint", route_port, 2);
    apply(2, 0, 2, 1, 0, 0, 0);
    check(route_port == 5'b01000 && !route_phase, "R4 north after X done", route_port, 8);
    apply(2, 1, 2, 1, 0, 3, 0);
    check(route_port == 5'b00100 && route_phase, "R5 turn at waypoint heads west", route_port, 4);
    apply(1, 2, 1, 2, 1, 2, 0);
    check(route_port == 5'b00001 && route_phase, "R5 waypoint is destination ejects", route_port, 1);
    apply(3, 3, 0, 0, 3, 0, 1);
    check(route_port == 5'b10000 && route_phase, "R6 south toward destination", route_port, 16);
    apply(2, 2, 0, 0, 2, 2, 1);
    check(route_port == 5'b00001, "R7 local at destination in phase 1", route_port, 1);
    apply(2, 2, 3, 3, 2, 2, 0);
    check(route_port == 5'b00010 && !route_phase, "R7 no eject at destination in phase 0",
          route_port, 2);

    // R8 and R4-R6: random headers against the bench model
    for (int i = 0; i < 400; i++) begin
      int cx, cy, mx, my, dx, dy, ph, ep;
      cx = $urandom % MX; cy = $urandom % MY; mx = $urandom % MX; my = $urandom % MY;
      dx = $urandom % MX; dy = $urandom % MY; ph = $urandom % 2;
      apply(cx, cy, mx, my, dx, dy, ph);
      ep = exp_port(cx, cy, mx, my, dx, dy, ph);
      if (route_port != 5'(ep) || route_phase != 1'(exp_phase(cx, cy, mx, my, ph)))
        check(1'b0, "R8 random header R4 R5 R6", route_port, ep);
      else if ($countones(route_port) != 1)
        check(1'b0, "R8 one-hot", route_port, ep);
      else
        check(1'b1, "R8", 0, 0);
    end

    // R9, R10: full walks
    walk(0, 0, 1, 2, 3, 3, "R9 example route");
    walk(1, 3, 1, 3, 3, 0, "R10 waypoint equals source");
    walk(3, 0, 0, 2, 0, 2, "R10 waypoint equals destination");
    walk(2, 2, 0, 0, 3, 1, "R9 detour walk");
    for (int i = 0; i < 20; i++)
      walk($urandom % MX, $urandom % MY, $urandom % MX, $urandom % MY,
           $urandom % MX, $urandom % MY, "R9 random walk");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule